// File: doc/BRIEF.md
# Failsafe Watchdog / Interval Timer

This block is a 16-bit supervisory counter. It can run in two ways. In watchdog mode, if software does not restart the count in time, the counter expires and the block asks for a system reset. In interval mode, the same expiry raises a sticky interrupt flag and the count starts again.

Software reaches the block through a single control word. A write takes effect only when the upper byte carries a fixed key. Any other key counts as a fault and raises a reset request at once.

Each clock reaches the block as a one-cycle advance strobe on the system clock. There are three of them:
- the main clock;
- a fast subsystem clock;
- a slow auxiliary clock.

The counter advances on the strobes of the subsystem or auxiliary clock, whichever is selected. Each of those two clocks has an "alive" indicator. If the selected clock's indicator drops, the counter moves over to the main-clock strobes.

While the block is running in watchdog mode, it drives a one-hot request for the clock it is actually using. This stops a low-power mode from switching that clock off.

The core is a three-state machine:
- `S_RUN`: the counter advances.
- `S_HOLD`: the count is frozen.
- `S_BARK`: a one-cycle reset-request state.

Its transitions are:
- **RUN↔HOLD**: an accepted write sets or clears the hold bit.
- **RUN/HOLD→BARK**: a write with the wrong key, or an expiry in watchdog mode.
- **BARK→RUN**: unconditional, after one cycle. The control fields return to their reset values and the count is zeroed.

Top module: `wdt_failsafe_top`

## Requirements
- R1: After reset the outputs are as follows: `rst_req`=0, `irq_flag`=0, `clk_req`=3'b010. The block runs in watchdog mode, on the subsystem source, with the 32768-tick interval.
- R2: A write is accepted only when `wr_data[15:8]` equals 8'h5A. Any other key drives `rst_req` high for exactly the cycle after the write edge, and all control fields return to their reset values.
- R3: `wr_data[1:0]` selects the interval: 00 gives 32768 ticks, 01 gives 8192, 10 gives 512 and 11 gives 64. The count reaching that value is an expiry, and the expiry zeroes the count.
- R4: With `wr_data[4]`=1 (interval mode), an expiry sets `irq_flag` and raises no reset request. `irq_flag` stays high until `irq_clr` is sampled high.
- R5: With `wr_data[4]`=0 (watchdog mode), an expiry drives `rst_req` high for one cycle. The control fields then return to their reset values.
- R6: `wr_data[7]`=1 (hold) freezes the count and keeps its value. A later accepted write with `wr_data[7]`=0 resumes counting from that value.
- R7: `wr_data[3]`=1 (clear) zeroes the count on the edge after the write, and then the bit clears itself. With one tick per cycle, the expiry therefore lands on the (P+1)-th edge after such a write.
- R8: `wr_data[2]` selects the source: 0 is the subsystem strobes, 1 is the auxiliary strobes. The strobes of the source that is not selected have no effect.
- R9: When the selected source's alive input is low, the counter advances on `tick_main` instead.
- R10: Each alive input passes through two flops before it changes the source. A drop therefore changes `clk_req` on the second edge after it.
- R11: `clk_req` is one-hot: [2]=auxiliary, [1]=subsystem, [0]=main. It is non-zero only in `S_RUN` in watchdog mode, and it names the source actually in use, including the main-clock fallback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 16 | Key in [15:8], control fields in [7:0] |
| irq_clr | input | 1 | Clears the interval flag |
| tick_main | input | 1 | Main-clock advance strobe |
| tick_sub | input | 1 | Subsystem-clock advance strobe |
| tick_aux | input | 1 | Auxiliary-clock advance strobe |
| sub_alive | input | 1 | Subsystem clock running |
| aux_alive | input | 1 | Auxiliary clock running |
| clk_req | output | 3 | One-hot request for the clock in use |
| rst_req | output | 1 | One-cycle system reset request |
| irq_flag | output | 1 | Sticky interval-expiry flag |

## Verification
The count cannot be read directly, so a wrong count shows up only as an expiry on the wrong edge. Each case starts from a clear write and waits for the edge at which the flag or reset request should first rise. The case checks that the output is still low one edge before that point and high on it. This exposes an off-by-one, a wrong tap, a lost hold value or a missed clear within a single interval. A wrong state or control value after a bark shows within a few hundred cycles. The 64-tick setting, which was active before the bark, must not fire again. A wrong source choice shows immediately on `clk_req`, and as a missing or early expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        S_RUN  = 2'd0,
        S_HOLD = 2'd1,
        S_BARK = 2'd2
    } wdt_state_e;

    typedef struct packed {
        logic       interval;
        logic       clr;
        logic       use_aux;
        logic [1:0] tap;
    } wdt_ctrl_t;

    localparam int REQ_AUX  = 2;
    localparam int REQ_SUB  = 1;
    localparam int REQ_MAIN = 0;

endpackage

// File: rtl/wdt_clk_sel.sv
module wdt_clk_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       use_aux,
    input  logic       req_on,
    input  logic       sub_alive,
    input  logic       aux_alive,
    input  logic       tick_main,
    input  logic       tick_sub,
    input  logic       tick_aux,
    output logic       tick_eff,
    output logic [2:0] clk_req
);
    import wdt_pkg::*;

    localparam int NCH = 2;

    logic [NCH-1:0]         alive_in;
    logic [SYNC_STAGES-1:0] sync_q [NCH];
    logic                   sub_ok;
    logic                   aux_ok;
    logic [2:0]             src_oh;

    assign alive_in = {aux_alive, sub_alive};

    for (genvar g = 0; g < NCH; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q[g] <= '1;
            end else begin
                sync_q[g] <= {sync_q[g][SYNC_STAGES-2:0], alive_in[g]};
            end
        end
    end

    assign sub_ok = sync_q[0][SYNC_STAGES-1];
    assign aux_ok = sync_q[1][SYNC_STAGES-1];

    always_comb begin
        src_oh = '0;
        if (use_aux && aux_ok) begin
            tick_eff        = tick_aux;
            src_oh[REQ_AUX] = 1'b1;
        end else if (!use_aux && sub_ok) begin
            tick_eff        = tick_sub;
            src_oh[REQ_SUB] = 1'b1;
        end else begin
            tick_eff         = tick_main;
            src_oh[REQ_MAIN] = 1'b1;
        end
        clk_req = req_on ? src_oh : 3'b000;
    end

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clk_req)); // R11

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 16,
    parameter int TAP0  = 15,
    parameter int TAP1  = 13,
    parameter int TAP2  = 9,
    parameter int TAP3  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_en,
    input  logic       tick,
    input  logic       clr,
    input  logic [1:0] tap_sel,
    output logic       expire
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] tap_mask;

    always_comb begin
        unique case (tap_sel)
            2'd0:    tap_mask = ONE << TAP0;
            2'd1:    tap_mask = ONE << TAP1;
            2'd2:    tap_mask = ONE << TAP2;
            default: tap_mask = ONE << TAP3;
        endcase
        cnt_nx = cnt + ONE;
        expire = cnt_en && tick && !clr && (|(cnt_nx & tap_mask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || expire) begin
            cnt <= '0;
        end else if (cnt_en && tick) begin
            cnt <= cnt_nx;
        end
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R7

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(cnt_en && tick)) |=> $stable(cnt)); // R6

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
    parameter logic [7:0] KEY = 8'h5A
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [15:0]         wr_data,
    input  logic                irq_clr,
    input  logic                expire,
    output wdt_pkg::wdt_ctrl_t  ctrl,
    output logic                cnt_en,
    output logic                cnt_clr,
    output logic                req_on,
    output logic                rst_req,
    output logic                irq_flag
);
    import wdt_pkg::*;

    wdt_state_e state;
    wdt_state_e st_d;
    logic       key_ok;
    logic       wr_ok;
    logic       wr_bad;
    logic       unused_rsvd;

    assign key_ok      = (wr_data[15:8] == KEY);
    assign wr_ok       = wr_en && key_ok && (state != S_BARK);
    assign wr_bad      = wr_en && !key_ok && (state != S_BARK);
    assign unused_rsvd = ^wr_data[6:5];

    always_comb begin
        st_d = state;
        unique case (state)
            S_BARK: st_d = S_RUN;
            S_RUN, S_HOLD: begin
                if (wr_bad || (expire && !ctrl.interval)) begin
                    st_d = S_BARK;
                end else if (wr_ok) begin
                    st_d = wr_data[7] ? S_HOLD : S_RUN;
                end
            end
            default: st_d = S_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_RUN;
        end else begin
            state <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl     <= '0;
            irq_flag <= 1'b0;
        end else begin
            if (st_d == S_BARK) begin
                ctrl <= '0;
            end else if (wr_ok) begin
                ctrl <= '{interval: wr_data[4], clr: wr_data[3],
                          use_aux: wr_data[2], tap: wr_data[1:0]};
            end else begin
                ctrl.clr <= 1'b0;
            end
            if (expire && ctrl.interval) begin
                irq_flag <= 1'b1;
            end else if (irq_clr) begin
                irq_flag <= 1'b0;
            end
        end
    end

    always_comb begin
        rst_req = (state == S_BARK);
        cnt_en  = (state == S_RUN);
        cnt_clr = ctrl.clr || (state == S_BARK);
        req_on  = (state == S_RUN) && !ctrl.interval;
    end

    AST_BAD_KEY_BARKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad |=> rst_req); // R2

    AST_BARK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (!rst_req && state == S_RUN && ctrl == '0)); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag); // R4

    AST_INTERVAL_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl.interval && !wr_bad) |=> !rst_req); // R4

endmodule

// File: rtl/wdt_failsafe_top.sv
module wdt_failsafe_top #(
    parameter int         CNT_W       = 16,
    parameter logic [7:0] KEY         = 8'h5A,
    parameter int         SYNC_STAGES = 2,
    parameter int         TAP0        = 15,
    parameter int         TAP1        = 13,
    parameter int         TAP2        = 9,
    parameter int         TAP3        = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        irq_clr,
    input  logic        tick_main,
    input  logic        tick_sub,
    input  logic        tick_aux,
    input  logic        sub_alive,
    input  logic        aux_alive,
    output logic [2:0]  clk_req,
    output logic        rst_req,
    output logic        irq_flag
);
    import wdt_pkg::*;

    wdt_ctrl_t ctrl;
    logic      cnt_en;
    logic      cnt_clr;
    logic      req_on;
    logic      tick_eff;
    logic      expire;

    wdt_ctrl #(.KEY(KEY)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .irq_clr  (irq_clr),
        .expire   (expire),
        .ctrl     (ctrl),
        .cnt_en   (cnt_en),
        .cnt_clr  (cnt_clr),
        .req_on   (req_on),
        .rst_req  (rst_req),
        .irq_flag (irq_flag)
    );

    wdt_clk_sel #(.SYNC_STAGES(SYNC_STAGES)) u_clk_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .use_aux   (ctrl.use_aux),
        .req_on    (req_on),
        .sub_alive (sub_alive),
        .aux_alive (aux_alive),
        .tick_main (tick_main),
        .tick_sub  (tick_sub),
        .tick_aux  (tick_aux),
        .tick_eff  (tick_eff),
        .clk_req   (clk_req)
    );

    wdt_counter #(
        .CNT_W (CNT_W),
        .TAP0  (TAP0),
        .TAP1  (TAP1),
        .TAP2  (TAP2),
        .TAP3  (TAP3)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .tick    (tick_eff),
        .clr     (cnt_clr),
        .tap_sel (ctrl.tap),
        .expire  (expire)
    );

    AST_NO_REQ_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en || ctrl.interval) |-> (clk_req == 3'b000)); // R11

    AST_RESET_XOR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> !rst_req); // R4

endmodule

// File: tb/sim_wdt_failsafe_top.sv
module sim_wdt_failsafe_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        irq_clr = 1'b0;
    logic        tick_main = 1'b0;
    logic        tick_sub = 1'b1;
    logic        tick_aux = 1'b0;
    logic        sub_alive = 1'b1;
    logic        aux_alive = 1'b1;
    logic [2:0]  clk_req;
    logic        rst_req;
    logic        irq_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [15:0] K    = 16'h5A00;
    localparam logic [15:0] HOLD = 16'h0080;
    localparam logic [15:0] INTV = 16'h0010;
    localparam logic [15:0] CLR  = 16'h0008;
    localparam logic [15:0] AUX  = 16'h0004;

    always #2 clk = ~clk;

    wdt_failsafe_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .irq_clr(irq_clr), .tick_main(tick_main), .tick_sub(tick_sub),
        .tick_aux(tick_aux), .sub_alive(sub_alive), .aux_alive(aux_alive),
        .clk_req(clk_req), .rst_req(rst_req), .irq_flag(irq_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic flag_clear();
        @(negedge clk);
        irq_clr = 1'b1;
        @(posedge clk);
        #1;
        irq_clr = 1'b0;
    endtask

    function automatic int period_of(input int t);
        int b;
        case (t)
            0: b = 15;
            1: b = 13;
            2: b = 9;
            default: b = 6;
        endcase
        return 1 << b;
    endfunction

    // flag (sel=0) or reset request (sel=1) low after p edges, high after p+1
    task automatic expect_edge(input string req, input bit sel, input int p);
        adv(p);
        chk(req, sel ? rst_req : irq_flag, 0);
        adv(1);
        chk(req, sel ? rst_req : irq_flag, 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 rst_req", rst_req, 0);
        chk("R1 irq_flag", irq_flag, 0);
        chk("R1 clk_req", clk_req, 3'b010);
        // R1 R3 default interval 32768 in watchdog mode from reset
        expect_edge("R1 R3 default expiry", 1'b1, 32767);
        adv(1);
        chk("R5 one-cycle bark", rst_req, 0);

        // R3 R4 R7 sweep of all taps in interval mode
        for (int t = 0; t < 4; t++) begin
            flag_clear();
            wr(K | INTV | CLR | 16'(t));
            expect_edge("R3 R4 R7 interval tap", 1'b0, period_of(t));
            chk("R4 no reset in interval", rst_req, 0);
        end
        adv(20);
        chk("R4 flag sticky", irq_flag, 1);
        flag_clear();
        chk("R4 flag cleared", irq_flag, 0);

        // R7 re-clear restarts the count
        wr(K | INTV | CLR | 16'd3);
        adv(40);
        wr(K | INTV | CLR | 16'd3);
        expect_edge("R7 clear restarts", 1'b0, 64);

        // R5 watchdog expiry then default restore
        flag_clear();
        wr(K | CLR | 16'd3);
        expect_edge("R5 watchdog tap64", 1'b1, 64);
        adv(1);
        chk("R5 bark one cycle", rst_req, 0);
        adv(300);
        chk("R5 tap restored to 32768", rst_req, 0);

        // R2 bad key
        wr(K | INTV | CLR | 16'd3);
        wr(16'hA500 | INTV | 16'd3);
        chk("R2 bad key reset", rst_req, 1);
        adv(1);
        chk("R2 bark one cycle", rst_req, 0);
        adv(300);
        chk("R2 fields restored (no interval flag)", irq_flag, 0);
        chk("R2 fields restored (no reset)", rst_req, 0);

        // R6 hold keeps count
        wr(K | INTV | CLR | 16'd3);
        adv(29);
        wr(K | INTV | HOLD | 16'd3);
        chk("R11 no request in hold", clk_req, 3'b000);
        adv(300);
        chk("R6 frozen no flag", irq_flag, 0);
        wr(K | INTV | 16'd3);
        expect_edge("R6 resume from held value", 1'b0, 34);

        // R8 R9 R10 R11 sources
        flag_clear();
        wr(K);
        chk("R11 sub request", clk_req, 3'b010);
        wr(K | AUX);
        chk("R8 R11 aux request", clk_req, 3'b100);
        @(negedge clk);
        aux_alive = 1'b0;
        adv(1);
        chk("R10 first sync edge", clk_req, 3'b100);
        adv(1);
        chk("R9 R10 fallback request", clk_req, 3'b001);
        wr(K | INTV | AUX);
        chk("R11 no request in interval", clk_req, 3'b000);

        tick_sub = 1'b0; tick_aux = 1'b0; tick_main = 1'b1;
        wr(K | INTV | CLR | AUX | 16'd3);
        expect_edge("R9 counts on main", 1'b0, 64);

        aux_alive = 1'b1;
        tick_aux = 1'b1; tick_main = 1'b0;
        adv(3);
        flag_clear();
        wr(K | INTV | CLR | AUX | 16'd3);
        expect_edge("R8 counts on aux", 1'b0, 64);

        flag_clear();
        tick_sub = 1'b0; tick_aux = 1'b1; tick_main = 1'b1;
        wr(K | INTV | CLR | 16'd3);
        adv(300);
        chk("R8 unselected strobes ignored", irq_flag, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule